// File: doc/BRIEF.md
# Dual-Key Flash Lock Controller

This block guards the control register of an embedded flash programming unit. After reset the control register refuses every write except a relock. Software opens it by writing two fixed 32-bit key words, one after the other, to a key register. A second key register, with its own sequencer, opens an accelerated programming mode. That mode can only be opened once the normal lock is open. Each sequencer holds its own lock flag, and both flags can be read in the control register. A wrong key jams the sequencer that received it, and only a reset clears the jam.

Software relocks by setting the standard lock bit in the control register. This also closes the fast mode. Setting only the fast lock bit closes the fast mode and leaves normal access open. The remaining control bits are stored for the programming unit and driven out on `ctrl_o`. A field of those bits, bits 19 to 16 by default, belongs to the fast mode. That field can be written only while the fast mode is open, and it is cleared whenever the fast mode closes. The flash array, its timing and its page buffer lie outside this block.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset both lock flags are 1, all other control bits are 0, and a read at offset 0x10 returns 0x00008080.
- R2: Writing 0x45670123 and then 0xCDEF89AB as two consecutive writes to offset 0x04 clears the standard lock. The flag reads 0 from the cycle after the second write. The first key alone leaves the flag set.
- R3: While the standard lock is set, a key-register write that breaks the sequence jams the standard sequencer. This covers a wrong value, or 0xCDEF89AB with no pending 0x45670123. A jammed sequencer keeps the lock set through any later key writes until reset.
- R4: The same two values written consecutively to offset 0x24 clear the fast lock, but only while the standard lock is clear. Writes to 0x24 while the standard lock is set change nothing. They neither advance nor jam the fast sequencer.
- R5: A broken sequence at offset 0x24 while the standard lock is clear jams the fast sequencer until reset. The standard lock is unaffected.
- R6: A control write with bit 7 set sets both lock flags. It also discards a half-entered key sequence, so a following 0xCDEF89AB counts as a broken sequence.
- R7: A control write with bit 15 set and bit 7 clear sets only the fast lock. The standard lock stays clear, and a new fast sequence can open the fast mode again.
- R8: Control bits outside bits 7, 15 and 19..16 are stored from a control write only when the standard lock was clear before that write. Otherwise they keep their value. A write with bit 7 clear never clears a lock.
- R9: Control bits 19..16 are stored only when the fast lock was clear before the write and the write sets neither bit 7 nor bit 15. They are forced to 0 by any write that sets bit 7 or 15, and they stay 0 while the fast lock is set.
- R10: A read at 0x10 returns the stored bits, with the standard lock at bit 7 and the fast lock at bit 15. Reads at any other offset, the key registers included, return 0. `ctrl_o` always equals the 0x10 read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| std_lock_o | output | 1 | Standard lock flag |
| fast_lock_o | output | 1 | Fast-mode lock flag |
| ctrl_o | output | 32 | Control word seen by the programming unit |

## Verification
Each sequencer keeps hidden state: a half-entered key, or a jam. That state does not show in a register until a later key write. Each key write is therefore followed in the next cycle by a check of both flags and the control word. This way a sequencer stuck half-way or wrongly jammed shows up on the following key write, not many operations later. Random runs reset every few dozen writes, so both the open and the jammed states are reached often. The directed cases cover the quieter states: a pending first key discarded by a relock, and a fast-key write ignored while the standard lock is set.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  // Sequencer states; all-zero encoding is the locked idle state.
  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_JAMMED = 2'd3
  } kseq_t;

  localparam int NUM_SEQ = 2;
  localparam int SEQ_STD  = 0;
  localparam int SEQ_FAST = 1;
endpackage

// File: rtl/flk_rst_sync.sv
module flk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/flk_key_seq.sv
module flk_key_seq
  import flk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              relock_i,
  output logic              locked_o
);
  kseq_t state_q;
  kseq_t state_d;
  logic  state_en;

  // Register updates only on a relock or an armed key write.
  assign state_en = relock_i | (wr_i & arm_i);

  always_comb begin
    state_d = state_q;
    if (relock_i) begin
      if (state_q != KS_JAMMED) state_d = KS_IDLE;
    end else if (wr_i && arm_i) begin
      unique case (state_q)
        KS_IDLE:   state_d = (wdata_i == KEY_FIRST)  ? KS_HALF : KS_JAMMED;
        KS_HALF:   state_d = (wdata_i == KEY_SECOND) ? KS_OPEN : KS_JAMMED;
        KS_OPEN:   state_d = KS_OPEN;
        KS_JAMMED: state_d = KS_JAMMED;
        default:   state_d = KS_JAMMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign locked_o = (state_q != KS_OPEN);

  // R2: opening happens only from the half state on the second key
  assert_open_from_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != KS_OPEN) ##1 (state_q == KS_OPEN) |->
      ($past(state_q) == KS_HALF && $past(wr_i && arm_i && wdata_i == KEY_SECOND)));

  // R3: a jam never clears without reset
  assert_jam_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_JAMMED) |=> (state_q == KS_JAMMED));

  // R4: an unarmed sequencer ignores key writes
  assert_unarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !relock_i) |=> $stable(state_q));
endmodule

// File: rtl/flk_ctrl_reg.sv
module flk_ctrl_reg #(
  parameter int              DATA_W    = 32,
  parameter int              STD_BIT   = 7,
  parameter int              FAST_BIT  = 15,
  parameter logic [DATA_W-1:0] FAST_MASK = 32'h000F_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              std_locked_i,
  input  logic              fast_locked_i,
  output logic              std_relock_o,
  output logic              fast_relock_o,
  output logic [DATA_W-1:0] bits_o
);
  localparam logic [DATA_W-1:0] LOCK_MASK  = (DATA_W'(1) << STD_BIT) | (DATA_W'(1) << FAST_BIT);
  localparam logic [DATA_W-1:0] PLAIN_MASK = ~(LOCK_MASK | FAST_MASK);

  logic [DATA_W-1:0] plain_q, plain_d;
  logic [DATA_W-1:0] fast_q, fast_d;
  logic              plain_en, fast_en;

  assign std_relock_o  = wr_i & wdata_i[STD_BIT];
  assign fast_relock_o = wr_i & (wdata_i[STD_BIT] | wdata_i[FAST_BIT]);

  assign plain_en = wr_i & ~std_locked_i;
  assign fast_en  = wr_i & (fast_relock_o | ~fast_locked_i);

  always_comb begin
    plain_d = wdata_i & PLAIN_MASK;
    fast_d  = fast_relock_o ? '0 : (wdata_i & FAST_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q <= '0;
    end else if (plain_en) begin
      plain_q <= plain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
    end else if (fast_en) begin
      fast_q <= fast_d;
    end
  end

  assign bits_o = plain_q | fast_q;

  // R8: plain bits frozen while the standard lock is set
  assert_plain_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    std_locked_i |=> $stable(plain_q));

  // R9: fast field reads zero whenever the fast lock is set
  assert_fast_field_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_locked_i |-> (fast_q == '0));
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flk_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 32,
  parameter logic [ADDR_W-1:0] KEY_OFF   = 8'h04,
  parameter logic [ADDR_W-1:0] MKEY_OFF  = 8'h24,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 8'h10,
  parameter int               STD_BIT   = 7,
  parameter int               FAST_BIT  = 15,
  parameter logic [DATA_W-1:0] FAST_MASK = 32'h000F_0000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              std_lock_o,
  output logic              fast_lock_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic rst_sync_n;

  flk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [NUM_SEQ-1:0] seq_arm, seq_wr, seq_relock, seq_locked;
  logic               ctrl_wr, std_relock, fast_relock;
  logic [DATA_W-1:0]  ctrl_bits, ctrl_word;

  assign ctrl_wr = bus_wr & (bus_addr == CTRL_OFF);

  assign seq_wr[SEQ_STD]      = bus_wr & (bus_addr == KEY_OFF);
  assign seq_wr[SEQ_FAST]     = bus_wr & (bus_addr == MKEY_OFF);
  assign seq_arm[SEQ_STD]     = 1'b1;
  assign seq_arm[SEQ_FAST]    = ~seq_locked[SEQ_STD];
  assign seq_relock[SEQ_STD]  = std_relock;
  assign seq_relock[SEQ_FAST] = fast_relock;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    flk_key_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .arm_i    (seq_arm[g]),
      .wr_i     (seq_wr[g]),
      .wdata_i  (bus_wdata),
      .relock_i (seq_relock[g]),
      .locked_o (seq_locked[g])
    );
  end

  flk_ctrl_reg #(
    .DATA_W    (DATA_W),
    .STD_BIT   (STD_BIT),
    .FAST_BIT  (FAST_BIT),
    .FAST_MASK (FAST_MASK)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_i          (ctrl_wr),
    .wdata_i       (bus_wdata),
    .std_locked_i  (seq_locked[SEQ_STD]),
    .fast_locked_i (seq_locked[SEQ_FAST]),
    .std_relock_o  (std_relock),
    .fast_relock_o (fast_relock),
    .bits_o        (ctrl_bits)
  );

  always_comb begin
    ctrl_word           = ctrl_bits;
    ctrl_word[STD_BIT]  = seq_locked[SEQ_STD];
    ctrl_word[FAST_BIT] = seq_locked[SEQ_FAST];
  end

  assign bus_rdata   = (bus_addr == CTRL_OFF) ? ctrl_word : '0;
  assign ctrl_o      = ctrl_word;
  assign std_lock_o  = seq_locked[SEQ_STD];
  assign fast_lock_o = seq_locked[SEQ_FAST];

  // R4: fast mode open implies normal access open
  assert_fast_needs_std_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seq_locked[SEQ_FAST] |-> !seq_locked[SEQ_STD]);

  // R6: relock through the control register closes both
  assert_relock_both_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == CTRL_OFF && bus_wdata[STD_BIT]) |=> (std_lock_o && fast_lock_o));

  // R7: fast-only relock keeps normal access state
  assert_fast_relock_only_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == CTRL_OFF && bus_wdata[FAST_BIT] && !bus_wdata[STD_BIT])
      |=> (fast_lock_o && $stable(std_lock_o)));
endmodule

// File: tb/tb_flash_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flash_lock_ctrl;
  localparam logic [31:0] KA    = 32'h4567_0123;
  localparam logic [31:0] KB    = 32'hCDEF_89AB;
  localparam logic [7:0]  A_KEY = 8'h04;
  localparam logic [7:0]  A_MK  = 8'h24;
  localparam logic [7:0]  A_CR  = 8'h10;
  localparam logic [31:0] FMASK = 32'h000F_0000;
  localparam logic [31:0] PMASK = ~(32'h0000_8080 | FMASK);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, ctrl_o;
  logic        std_lock_o, fast_lock_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model: 0 idle, 1 half, 2 open, 3 jammed
  int          m_std, m_fast;
  logic [31:0] m_plain, m_fastf;

  always #5 clk = ~clk;

  flash_lock_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .std_lock_o (std_lock_o),
    .fast_lock_o(fast_lock_o),
    .ctrl_o     (ctrl_o)
  );

  function automatic int seq_step(int s, logic [31:0] d);
    case (s)
      0:       return (d == KA) ? 1 : 3;
      1:       return (d == KB) ? 2 : 3;
      default: return s;
    endcase
  endfunction

  function automatic int seq_rel(int s);
    return (s == 3) ? 3 : 0;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v;
    v     = m_plain | m_fastf;
    v[7]  = (m_std != 2);
    v[15] = (m_fast != 2);
    return v;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_apply(logic [7:0] a, logic [31:0] d);
    bit sl, fl;
    if (a == A_KEY) m_std = seq_step(m_std, d);
    else if (a == A_MK) begin
      if (m_std == 2) m_fast = seq_step(m_fast, d);
    end else if (a == A_CR) begin
      sl = (m_std != 2);
      fl = (m_fast != 2);
      if (!sl) m_plain = d & PMASK;
      if (d[7] || d[15]) m_fastf = '0;
      else if (!fl) m_fastf = d & FMASK;
      if (d[7]) begin m_std = seq_rel(m_std); m_fast = seq_rel(m_fast); end
      if (d[15]) m_fast = seq_rel(m_fast);
    end
  endtask

  task automatic check_all(string req);
    bus_addr = A_CR;
    #1;
    chk(req, "rdata", bus_rdata, exp_ctrl());
    chk(req, "ctrl_o", ctrl_o, exp_ctrl());
    chk(req, "std_lock", {31'd0, std_lock_o}, {31'd0, m_std != 2});
    chk(req, "fast_lock", {31'd0, fast_lock_o}, {31'd0, m_fast != 2});
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_wr = 1'b0;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_std = 0; m_fast = 0; m_plain = '0; m_fastf = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_apply(a, d);
    check_all(req);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  a;
    logic [31:0] d;
    int          r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    void'($urandom(32'd20240611));

    // R1: reset state
    do_reset();
    bus_addr = A_CR; #1;
    chk("R1", "reset read", bus_rdata, 32'h0000_8080);
    check_all("R1");

    // R2: normal unlock; first key alone keeps lock
    wr(A_KEY, KA, "R2");
    chk("R2", "half lock", {31'd0, std_lock_o}, 32'd1);
    wr(A_KEY, KB, "R2");
    chk("R2", "open lock", {31'd0, std_lock_o}, 32'd0);

    // R8: plain bits stored when open
    wr(A_CR, 32'h0000_0123, "R8");
    chk("R8", "stored", bus_rdata, 32'h0000_8123);

    // R4: fast unlock after normal unlock
    wr(A_MK, KA, "R4");
    wr(A_MK, KB, "R4");
    chk("R4", "fast open", bus_rdata, 32'h0000_0123);

    // R9: fast field writable while fast open
    wr(A_CR, 32'h000A_0123, "R9");
    chk("R9", "fast field", bus_rdata, 32'h000A_0123);

    // R7: fast-only relock clears fast field
    wr(A_CR, 32'h0000_8123, "R7");
    chk("R7", "fast relock", bus_rdata, 32'h0000_8123);
    wr(A_MK, KA, "R7");
    wr(A_MK, KB, "R7");
    chk("R7", "fast reopen", {31'd0, fast_lock_o}, 32'd0);

    // R6: relock both, then pending first key discarded
    wr(A_CR, 32'h0000_0080, "R6");
    chk("R6", "both locked", bus_rdata, 32'h0000_8080);
    wr(A_KEY, KA, "R6");
    wr(A_CR, 32'h0000_0080, "R6");
    wr(A_KEY, KB, "R6");
    wr(A_KEY, KA, "R3");
    wr(A_KEY, KB, "R3");
    chk("R3", "jam after discard", {31'd0, std_lock_o}, 32'd1);

    // R3: second key first jams
    do_reset();
    wr(A_KEY, KB, "R3");
    wr(A_KEY, KA, "R3");
    wr(A_KEY, KB, "R3");
    chk("R3", "jammed", {31'd0, std_lock_o}, 32'd1);
    do_reset();
    wr(A_KEY, KA, "R3");
    wr(A_KEY, 32'h1234_5678, "R3");
    wr(A_KEY, KA, "R3");
    wr(A_KEY, KB, "R3");
    chk("R3", "wrong second", {31'd0, std_lock_o}, 32'd1);

    // R8: locked control ignores writes, bit7 clear does not unlock
    wr(A_CR, 32'hFFFF_7F7F, "R8");
    chk("R8", "locked ignore", bus_rdata, 32'h0000_8080);

    // R4: mode key writes ignored while normal lock set
    do_reset();
    wr(A_MK, 32'hDEAD_BEEF, "R4");
    wr(A_KEY, KA, "R4");
    wr(A_KEY, KB, "R4");
    wr(A_MK, KA, "R4");
    wr(A_MK, KB, "R4");
    chk("R4", "no jam while locked", {31'd0, fast_lock_o}, 32'd0);

    // R5: fast jam
    do_reset();
    wr(A_KEY, KA, "R5");
    wr(A_KEY, KB, "R5");
    wr(A_MK, KB, "R5");
    wr(A_MK, KA, "R5");
    wr(A_MK, KB, "R5");
    chk("R5", "fast jammed", {31'd0, fast_lock_o}, 32'd1);
    chk("R5", "std open", {31'd0, std_lock_o}, 32'd0);
    // R9: fast field refused while fast locked
    wr(A_CR, 32'h0005_0001, "R9");
    chk("R9", "fast refused", bus_rdata, 32'h0000_8001);

    // R10: other offsets read zero
    bus_addr = A_KEY; #1;
    chk("R10", "key read", bus_rdata, 32'h0);
    bus_addr = A_MK; #1;
    chk("R10", "mode key read", bus_rdata, 32'h0);
    bus_addr = 8'h0C; #1;
    chk("R10", "other read", bus_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 2500; i++) begin
      if (i % 60 == 0) do_reset();
      r = int'($urandom % 8);
      if (r < 3) a = A_KEY;
      else if (r < 5) a = A_MK;
      else if (r < 7) a = A_CR;
      else a = 8'($urandom);
      if (a == A_CR) begin
        d = $urandom;
        if ($urandom % 8 != 0) d[7] = 1'b0;
        if ($urandom % 4 != 0) d[15] = 1'b0;
      end else begin
        r = int'($urandom % 8);
        d = (r < 3) ? KA : (r < 6) ? KB : $urandom;
      end
      wr(a, d, "R10");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule